// File: doc/BRIEF.md
# Byte-Burst SPI Register Target

This block is a 4-wire SPI target that gives a host access to a small map of 8-bit registers in a 15-bit address space. Every chip-select window opens with a 16-bit instruction: a direction flag followed by a register address. One or more data bytes follow it. The first data byte goes to or comes from the addressed register. Each further complete byte in the same window starts a new access. That access goes to the next address, the previous address or the same address again, as two mode bits in register zero select.

The SPI pins are brought into the system clock domain through two-flop synchronizers, and all decoding runs on the system clock. The SPI clock must therefore be slow compared with the system clock. Each completed write byte raises a single-cycle internal write strobe. A write to the low byte of the divider register also produces a one-cycle calibration pulse on an output. The register map holds a configuration register, a window of general read/write registers, a read-only identity register and a two-byte divider. Every other address is unused.

Top module: `spi_burst_regs`

## Requirements
- R1: The instruction word is sent MSB first and is sampled on rising SCK edges. Instruction bit 15 set to 1 means read and 0 means write, and bits 14:0 give the address. The first data byte after the instruction accesses that address.
- R2: When bit 3 of register 0x000 is 1, every further byte in the window accesses the same address, whatever the value of bit 2.
- R3: When bit 3 of register 0x000 is 0 and bit 2 is 1, each further byte accesses the address one above the previous one.
- R4: When bits 3 and 2 of register 0x000 are both 0, each further byte accesses the address one below the previous one, and 0x0000 steps to 0x7FFF. This is the mode after power-on.
- R5: Register 0x000 resets to 0x00. Writing it with bit 7 set returns every register to its default: 0x000 and the general registers to 0x00, the divider low byte to 0x64 and the divider high byte to 0x00. Bit 7 itself always reads back as 0.
- R6: The address step used inside a window is the mode that was in force when the instruction completed. A write to register 0x000 does not change the step for the rest of that window.
- R7: Writes to unused addresses have no effect, and reads of them return 0x00. The used addresses are 0x000, 0x002 to 0x00F, 0x010, 0x011 and 0x012.
- R8: Address 0x010 always reads as the identity value 0xA5 and ignores writes.
- R9: Each write to the divider low byte at 0x012 produces exactly one single-cycle pulse on cal_pulse. A write to any other address produces none.
- R10: If chip select rises partway through a byte, the partial byte is discarded and the next window starts cleanly with a new instruction.
- R11: Read data leaves on spi_miso MSB first and changes after falling SCK edges, so it is valid at the next rising edge. spi_miso is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| cal_pulse | output | 1 | One-cycle pulse after a divider low-byte write |

## Verification
The bench builds the block with the default parameters: a 15-bit address, general registers at 0x002 to 0x00F, identity at 0x010 and the divider at 0x011/0x012. With these values a descending step from 0x0000 lands on the unused address 0x7FFF. An ascending burst that starts at 0x00F crosses into the read-only identity register, so both address edges and the read-only rule can be tested in a single transaction. The bench holds SCK at 16 system cycles per bit, which leaves enough margin for the synchronizer delay before each sampling edge.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [1:0] {
    STEP_DOWN = 2'b00,
    STEP_UP   = 2'b01,
    STEP_HOLD = 2'b10
  } step_e;

  // The hold bit wins over the direction bit
  function automatic step_e decode_step(input logic [1:0] mode_bits);
    if (mode_bits[1]) return STEP_HOLD;
    if (mode_bits[0]) return STEP_UP;
    return STEP_DOWN;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_framer.sv
module spi_framer #(
  parameter int INSTR_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_act,
  input  logic               sck_rise,
  input  logic               mosi_s,
  output logic               instr_done,
  output logic [INSTR_W-1:0] instr_word,
  output logic               byte_done,
  output logic [BYTE_W-1:0]  byte_val
);
  localparam int CW = $clog2(INSTR_W);

  logic [INSTR_W-1:0] sh;
  logic [CW-1:0]      cnt;
  logic               in_instr;
  logic [INSTR_W-1:0] sh_next;

  assign sh_next    = {sh[INSTR_W-2:0], mosi_s};
  assign instr_done = cs_act && sck_rise && in_instr  && (cnt == CW'(INSTR_W-1));
  assign byte_done  = cs_act && sck_rise && !in_instr && (cnt == CW'(BYTE_W-1));
  assign instr_word = sh_next;
  assign byte_val   = sh_next[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      in_instr <= 1'b1;
    end else if (!cs_act) begin
      // A partial byte is dropped here
      cnt      <= '0;
      in_instr <= 1'b1;
    end else if (sck_rise) begin
      sh <= sh_next;
      if (instr_done) begin
        cnt      <= '0;
        in_instr <= 1'b0;
      end else if (byte_done) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int          ADDR_W      = 15,
  parameter int          GP_BASE     = 2,
  parameter int          GP_COUNT    = 14,
  parameter int          ID_ADDR     = 16,
  parameter logic [7:0]  ID_VAL      = 8'hA5,
  parameter int          DIV_HI_ADDR = 17,
  parameter int          DIV_LO_ADDR = 18,
  parameter logic [7:0]  DIV_HI_RST  = 8'h00,
  parameter logic [7:0]  DIV_LO_RST  = 8'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [1:0]        step_bits
);
  logic [6:0] cfg;
  logic [7:0] gp [GP_COUNT];
  logic [7:0] div_hi, div_lo;
  logic       soft_rst;

  assign soft_rst  = wr_stb && (wr_addr == '0) && wr_data[7];
  assign step_bits = cfg[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      div_hi <= DIV_HI_RST;
      div_lo <= DIV_LO_RST;
      for (int i = 0; i < GP_COUNT; i++) gp[i] <= '0;
    end else if (soft_rst) begin
      cfg    <= '0;
      div_hi <= DIV_HI_RST;
      div_lo <= DIV_LO_RST;
      for (int i = 0; i < GP_COUNT; i++) gp[i] <= '0;
    end else if (wr_stb) begin
      if (wr_addr == '0)                       cfg    <= wr_data[6:0];
      if (wr_addr == ADDR_W'(DIV_HI_ADDR))     div_hi <= wr_data;
      if (wr_addr == ADDR_W'(DIV_LO_ADDR))     div_lo <= wr_data;
      for (int i = 0; i < GP_COUNT; i++)
        if (wr_addr == ADDR_W'(GP_BASE + i))   gp[i]  <= wr_data;
    end
  end

  // Unused addresses fall through to zero
  always_comb begin
    rd_data = '0;
    if (rd_addr == '0)                      rd_data = {1'b0, cfg};
    if (rd_addr == ADDR_W'(ID_ADDR))        rd_data = ID_VAL;
    if (rd_addr == ADDR_W'(DIV_HI_ADDR))    rd_data = div_hi;
    if (rd_addr == ADDR_W'(DIV_LO_ADDR))    rd_data = div_lo;
    for (int i = 0; i < GP_COUNT; i++)
      if (rd_addr == ADDR_W'(GP_BASE + i))  rd_data = gp[i];
  end
endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
  import spi_burst_pkg::*;
#(
  parameter int          ADDR_W      = 15,
  parameter int          GP_BASE     = 2,
  parameter int          GP_COUNT    = 14,
  parameter int          ID_ADDR     = 16,
  parameter logic [7:0]  ID_VAL      = 8'hA5,
  parameter int          DIV_HI_ADDR = 17,
  parameter int          DIV_LO_ADDR = 18,
  parameter logic [7:0]  DIV_HI_RST  = 8'h00,
  parameter logic [7:0]  DIV_LO_RST  = 8'h64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic cal_pulse
);
  localparam int INSTR_W = ADDR_W + 1;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a, input step_e m);
    case (m)
      STEP_UP:   return a + ADDR_W'(1);
      STEP_DOWN: return a - ADDR_W'(1);
      default:   return a;
    endcase
  endfunction

  // Synchronized pins and SCK edge events
  logic csn_s, sck_s, mosi_s, sck_d;
  logic cs_act, sck_rise, sck_fall;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_csn, spi_sck, spi_mosi}),
    .q({csn_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign cs_act   = !csn_s;
  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;

  // Framing
  logic               instr_done, byte_done;
  logic [INSTR_W-1:0] instr_word;
  logic [7:0]         byte_val;

  spi_framer #(.INSTR_W(INSTR_W), .BYTE_W(8)) u_framer (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise), .mosi_s(mosi_s),
    .instr_done(instr_done), .instr_word(instr_word),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  // Address sequencer
  logic              rd_mode;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  step_e             step_snap;
  logic [1:0]        step_bits;
  logic              step_ev;

  assign nxt_addr = step_addr(cur_addr, step_snap);
  assign step_ev  = byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mode   <= 1'b0;
      cur_addr  <= '0;
      step_snap <= STEP_DOWN;
    end else if (instr_done) begin
      rd_mode   <= instr_word[ADDR_W];
      cur_addr  <= instr_word[ADDR_W-1:0];
      step_snap <= decode_step(step_bits);
    end else if (step_ev) begin
      cur_addr  <= nxt_addr;
    end
  end

  // Register access
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        rd_data;

  assign wr_stb  = byte_done && !rd_mode;
  assign wr_addr = cur_addr;
  assign rd_addr = instr_done ? instr_word[ADDR_W-1:0] : nxt_addr;

  spi_regfile #(
    .ADDR_W(ADDR_W), .GP_BASE(GP_BASE), .GP_COUNT(GP_COUNT),
    .ID_ADDR(ID_ADDR), .ID_VAL(ID_VAL),
    .DIV_HI_ADDR(DIV_HI_ADDR), .DIV_LO_ADDR(DIV_LO_ADDR),
    .DIV_HI_RST(DIV_HI_RST), .DIV_LO_RST(DIV_LO_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(byte_val),
    .rd_addr(rd_addr), .rd_data(rd_data), .step_bits(step_bits)
  );

  // Read shifter: load on byte boundary, shift out on falling SCK
  logic       rd_load;
  logic [7:0] rd_sh;
  logic       miso_q;

  assign rd_load = (instr_done && instr_word[ADDR_W]) || (byte_done && rd_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh  <= '0;
      miso_q <= 1'b0;
    end else if (!cs_act) begin
      rd_sh  <= '0;
      miso_q <= 1'b0;
    end else if (rd_load) begin
      rd_sh  <= rd_data;
    end else if (sck_fall) begin
      miso_q <= rd_sh[7];
      rd_sh  <= {rd_sh[6:0], 1'b0};
    end
  end

  assign spi_miso = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_pulse <= 1'b0;
    else        cal_pulse <= wr_stb && (wr_addr == ADDR_W'(DIV_LO_ADDR));
  end
endmodule

// File: rtl/spi_burst_regs_chk.sv
module spi_burst_regs_chk
  import spi_burst_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DIV_LO_ADDR = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cal_pulse,
  input logic              step_ev,
  input logic [ADDR_W-1:0] cur_addr,
  input step_e             step_snap,
  input logic              cs_act,
  input logic              spi_miso
);
  a_r9_cal_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |=> !cal_pulse);

  a_r9_cal_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == ADDR_W'(DIV_LO_ADDR)) |=> cal_pulse);

  a_r9_cal_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |-> $past(wr_stb && wr_addr == ADDR_W'(DIV_LO_ADDR)));

  a_r2_hold_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && step_snap == STEP_HOLD) |=> $stable(cur_addr));

  a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && step_snap == STEP_UP) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

  a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && step_snap == STEP_DOWN) |=> cur_addr == $past(cur_addr) - ADDR_W'(1));

  a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);
endmodule

bind spi_burst_regs spi_burst_regs_chk #(.ADDR_W(ADDR_W), .DIV_LO_ADDR(DIV_LO_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .cal_pulse(cal_pulse),
  .step_ev(step_ev), .cur_addr(cur_addr), .step_snap(step_snap),
  .cs_act(cs_act), .spi_miso(spi_miso)
);

// File: tb/tb_spi_burst_regs.sv
module tb_spi_burst_regs;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, cal_pulse;

  int total = 0, bad = 0;
  int cal_cnt = 0, cal_run = 0, cal_run_max = 0;
  logic [7:0] wb [4];
  logic [7:0] rb [4];

  always #5 clk = ~clk;

  spi_burst_regs #(
    .ADDR_W(15), .GP_BASE(2), .GP_COUNT(14), .ID_ADDR(16), .ID_VAL(8'hA5),
    .DIV_HI_ADDR(17), .DIV_LO_ADDR(18), .DIV_HI_RST(8'h00), .DIV_LO_RST(8'h64)
  ) dut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cal_pulse(cal_pulse)
  );

  always @(negedge clk) begin
    if (cal_pulse) begin
      cal_cnt++;
      cal_run++;
      if (cal_run > cal_run_max) cal_run_max = cal_run;
    end else cal_run = 0;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic d, output logic s);
    spi_mosi = d;
    wait_clk(HALF);
    s = spi_miso;
    spi_sck = 1'b1;
    wait_clk(HALF);
    spi_sck = 1'b0;
  endtask

  task automatic spi_xfer(input logic rd, input logic [14:0] addr, input int nb, input int partial);
    logic [15:0] iw;
    logic s;
    iw = {rd, addr};
    spi_csn = 1'b0;
    wait_clk(HALF);
    for (int i = 15; i >= 0; i--) send_bit(iw[i], s);
    for (int b = 0; b < nb; b++)
      for (int i = 7; i >= 0; i--) begin
        send_bit(wb[b][i], s);
        rb[b][i] = s;
      end
    for (int p = 0; p < partial; p++) send_bit(1'b1, s);
    wait_clk(HALF);
    spi_csn = 1'b1;
    wait_clk(12);
  endtask

  task automatic wr1(input logic [14:0] a, input logic [7:0] d);
    wb[0] = d;
    spi_xfer(1'b0, a, 1, 0);
  endtask

  task automatic rd1(input logic [14:0] a, output logic [7:0] d);
    wb[0] = 8'h00;
    spi_xfer(1'b1, a, 1, 0);
    d = rb[0];
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    chk("R11 miso idle", int'(spi_miso), 0);
    rd1(15'h000, d); chk("R5 cfg reset", d, 8'h00);
    rd1(15'h010, d); chk("R8 id value", d, 8'hA5);
    rd1(15'h012, d); chk("R5 div lo reset", d, 8'h64);
    rd1(15'h011, d); chk("R5 div hi reset", d, 8'h00);
  endtask

  task automatic t_descend;
    logic [7:0] d;
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33;
    spi_xfer(1'b0, 15'h005, 3, 0);
    rd1(15'h004, d); chk("R4 descend write 2nd", d, 8'h22);
    rd1(15'h003, d); chk("R4 descend write 3rd", d, 8'h33);
    wb[0] = 0; wb[1] = 0; wb[2] = 0;
    spi_xfer(1'b1, 15'h005, 3, 0);
    chk("R1 first read byte", rb[0], 8'h11);
    chk("R4 descend read 2nd", rb[1], 8'h22);
    chk("R4 descend read 3rd", rb[2], 8'h33);
  endtask

  task automatic t_wrap_unused;
    logic [7:0] d;
    wb[0] = 8'h04; wb[1] = 8'hFF;
    spi_xfer(1'b0, 15'h000, 2, 0);
    rd1(15'h000, d); chk("R6 cfg set to ascend", d, 8'h04);
    rd1(15'h7FFF, d); chk("R7 unused 0x7FFF reads zero", d, 8'h00);
    wr1(15'h001, 8'h5C);
    rd1(15'h001, d); chk("R7 unused write ignored", d, 8'h00);
  endtask

  task automatic t_ascend;
    logic [7:0] d;
    wb[0] = 8'hA1; wb[1] = 8'hA2; wb[2] = 8'hA3;
    spi_xfer(1'b0, 15'h00D, 3, 0);
    wb[0] = 0; wb[1] = 0; wb[2] = 0;
    spi_xfer(1'b1, 15'h00D, 3, 0);
    chk("R3 ascend 1st", rb[0], 8'hA1);
    chk("R3 ascend 2nd", rb[1], 8'hA2);
    chk("R3 ascend 3rd", rb[2], 8'hA3);
    wb[0] = 8'hB1; wb[1] = 8'h00;
    spi_xfer(1'b0, 15'h00F, 2, 0);
    rd1(15'h010, d); chk("R8 id ignores write", d, 8'hA5);
    rd1(15'h00F, d); chk("R3 ascend into id", d, 8'hB1);
  endtask

  task automatic t_snapshot;
    logic [7:0] d;
    wb[0] = 8'h0C; wb[1] = 8'h5A;
    spi_xfer(1'b0, 15'h000, 2, 0);
    rd1(15'h000, d); chk("R6 old mode kept in window", d, 8'h0C);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    wb[0] = 8'h01; wb[1] = 8'h02; wb[2] = 8'h03;
    spi_xfer(1'b0, 15'h006, 3, 0);
    rd1(15'h006, d); chk("R2 hold last byte wins", d, 8'h03);
    rd1(15'h005, d); chk("R2 hold below untouched", d, 8'h11);
    rd1(15'h007, d); chk("R2 hold above untouched", d, 8'h00);
    wb[0] = 0; wb[1] = 0; wb[2] = 0;
    spi_xfer(1'b1, 15'h006, 3, 0);
    chk("R2 hold read 2nd", rb[1], 8'h03);
    chk("R2 hold read 3rd", rb[2], 8'h03);
    wr1(15'h000, 8'h08);
    wb[0] = 8'h44; wb[1] = 8'h55;
    spi_xfer(1'b0, 15'h007, 2, 0);
    rd1(15'h007, d); chk("R2 hold bit2 clear", d, 8'h55);
    rd1(15'h008, d); chk("R2 hold bit2 clear neighbour", d, 8'h00);
  endtask

  task automatic t_partial;
    logic [7:0] d;
    wb[0] = 8'h99;
    spi_xfer(1'b0, 15'h003, 1, 5);
    rd1(15'h003, d); chk("R10 partial byte dropped", d, 8'h99);
  endtask

  task automatic t_cal;
    logic [7:0] d;
    int c0;
    c0 = cal_cnt;
    wr1(15'h012, 8'h37);
    chk("R9 one pulse on div lo write", cal_cnt - c0, 1);
    rd1(15'h012, d); chk("R9 div lo stored", d, 8'h37);
    c0 = cal_cnt;
    wr1(15'h011, 8'h12);
    chk("R9 no pulse on div hi write", cal_cnt - c0, 0);
    chk("R9 pulse width one cycle", cal_run_max, 1);
  endtask

  task automatic t_soft_reset;
    logic [7:0] d;
    wr1(15'h000, 8'h80);
    rd1(15'h000, d); chk("R5 cfg after soft reset", d, 8'h00);
    rd1(15'h006, d); chk("R5 gp after soft reset", d, 8'h00);
    rd1(15'h012, d); chk("R5 div lo after soft reset", d, 8'h64);
    rd1(15'h011, d); chk("R5 div hi after soft reset", d, 8'h00);
    wb[0] = 8'h71; wb[1] = 8'h72;
    spi_xfer(1'b0, 15'h005, 2, 0);
    rd1(15'h004, d); chk("R4 descend after soft reset", d, 8'h72);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset_state();
    t_descend();
    t_wrap_unused();
    t_ascend();
    t_snapshot();
    t_hold();
    t_partial();
    t_cal();
    t_soft_reset();
    chk("R11 miso idle at end", int'(spi_miso), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule